// File: doc/BRIEF.md
# Clock-Synchronous Serial Transmitter with Clear-to-Send Gating

This block sends bytes over a clocked serial link. Software pushes a byte into a one-entry holding buffer through a valid/ready write port. A transfer moves the buffered byte into a shift register. The byte then leaves on a single data line, least significant bit first. A transmit clock goes out beside the data line. The data line changes on every falling edge of that clock, so a receiver can sample on the rising edge. A transfer starts only when three things are true: the transmitter is enabled, the buffer is full, and the clear-to-send input is low. A configuration bit can drop the clear-to-send part of that check. Once a byte has started it always runs to its end, whatever the control inputs do.

The transmit clock is made by a simple internal divider, `HALF_CYC` system clocks per half period. It comes out on one of three clock pins, chosen by a 2-bit select, so up to three receivers can share one data line. The select is captured when each byte starts. The clock idles high, and pins that are not selected stay high. Status outputs show whether the buffer and the shift register are empty. A transmit interrupt request is raised each time the buffer hands its byte to the shift register.

The write port never applies back-pressure: `s_ready` is held at 1. A write while the buffer is already full replaces the pending byte. The start check also runs in the last half-period of each byte. A byte that is buffered and cleared to go before that point follows the previous byte with no idle gap.

Top module: `sync_ser_tx`

## Requirements
- R1: A byte is loaded into the shift register only when `tx_en` is 1, `buf_empty` is 0 and `cts_n` is 0. If any of these is false, no clock pin toggles and the byte stays buffered.
- R2: With `cts_ignore` at 1, `cts_n` has no effect on the start decision.
- R3: Each byte goes out LSB first. `sdata` changes only together with a falling edge of the transmit clock, so it is stable at each rising edge, where a receiver samples it.
- R4: A write (`s_valid` with `s_ready`, which is always 1) clears `buf_empty`. A load sets `buf_empty`. A second write before the load overwrites the pending byte, so only the last byte is sent.
- R5: After a byte has started, changes on `tx_en`, `cts_n` or `cts_ignore` do not shorten or stop it. All 8 bits are sent.
- R6: If the next byte is buffered and allowed to start before the final high half-period of the current byte ends, it starts on that edge. The clock then has no high stretch longer than one half-period between the two bytes.
- R7: `shreg_empty` goes to 1 one cycle after the rising clock edge of the last bit, and it goes to 0 on the cycle a byte is loaded.
- R8: `irq_req` is set when `buf_empty` rises from 0 to 1. A one-cycle `irq_clr` clears it, and a set in the same cycle wins.
- R9: `clk_sel` values 0, 1 and 2 route the transmit clock to `sclk_pins[0]`, `[1]` and `[2]`. The value 3 routes it to no pin. Unselected pins, and all pins while idle, are held at 1.
- R10: The clock select is captured when a byte starts. Changing `clk_sel` during a byte does not move that byte's clock to another pin.
- R11: After reset, `buf_empty`, `shreg_empty`, `sdata` and all clock pins are 1, and `irq_req` is 0.
- R12: Each low and each high half-period of the transmit clock lasts `HALF_CYC` system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable |
| cts_n | input | 1 | Clear-to-send, active low |
| cts_ignore | input | 1 | 1 = leave clear-to-send out of the start check |
| clk_sel | input | 2 | Clock pin select: 0, 1, 2 = pin index, 3 = none |
| s_valid | input | 1 | Write strobe for the transmit buffer |
| s_data | input | 8 | Byte to buffer |
| s_ready | output | 1 | Always 1; a write to a full buffer overwrites it |
| irq_clr | input | 1 | Clears the interrupt request |
| sdata | output | 1 | Serial data, LSB first |
| sclk_pins | output | 3 | Transmit clock outputs, idle high |
| buf_empty | output | 1 | Transmit buffer empty |
| shreg_empty | output | 1 | Shift register empty |
| irq_req | output | 1 | Transmit interrupt request |

## Verification
The bench checks that a held-high clear-to-send or a low enable really keeps a buffered byte at home, and that the bypass bit releases it. A design that loaded early would put clock edges on the pins too soon. It drops clear-to-send and enable in the middle of a byte and changes the clock select in the middle of a byte. A design that aborted, or re-routed the clock, would deliver fewer than eight rising edges on the original pin. Back-to-back writes are timed by the longest high stretch of the clock: a design that checked the start condition only when idle would show a gap longer than one half-period. A double write before enabling must send only the second byte, and the shift-register-empty flag must rise exactly one cycle after the last rising edge.

// File: rtl/sst_pkg.sv
package sst_pkg;
  typedef enum logic {
    SST_IDLE  = 1'b0,
    SST_SHIFT = 1'b1
  } sst_state_e;
endpackage

// File: rtl/sst_baud.sv
// Half-period tick generator for the transmit clock.
module sst_baud #(
  parameter int HALF_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] TOP = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= (cnt == TOP) ? '0 : cnt + 1'b1;
    end
  end

  assign tick = run && (cnt == TOP);
endmodule

// File: rtl/sst_shifter.sv
// Shift register, bit counter and transmit clock phase.
module sst_shifter
  import sst_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  input  logic              tick,
  output logic              sclk,
  output logic              sdata,
  output logic              busy,
  output logic              tend,
  output logic              load_win
);
  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BW-1:0] LASTB = BW'(DATA_W - 1);

  sst_state_e        st;
  logic [DATA_W-1:0] shreg;
  logic [BW-1:0]     bcnt;

  assign busy     = (st == SST_SHIFT);
  assign load_win = (st == SST_IDLE) || (tick && sclk && (bcnt == LASTB));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= SST_IDLE;
      shreg <= '0;
      bcnt  <= '0;
      sclk  <= 1'b1;
      sdata <= 1'b1;
      tend  <= 1'b0;
    end else if (load) begin
      st    <= SST_SHIFT;
      shreg <= din;
      bcnt  <= '0;
      sclk  <= 1'b0;
      sdata <= din[0];
      tend  <= 1'b0;
    end else if (busy && tick) begin
      if (!sclk) begin
        sclk <= 1'b1;
        if (bcnt == LASTB) tend <= 1'b1;
      end else if (bcnt == LASTB) begin
        st    <= SST_IDLE;
        sdata <= 1'b1;
        tend  <= 1'b0;
      end else begin
        sclk  <= 1'b0;
        bcnt  <= bcnt + 1'b1;
        shreg <= shreg >> 1;
        sdata <= shreg[1];
      end
    end
  end

  // R3: while shifting, a data change always comes with a low clock
  assert_data_moves_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(sdata)) |-> !sclk);

  // R9: the internal clock rests high whenever no byte is in flight
  assert_idle_clock_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> sclk);
endmodule

// File: rtl/sst_clkroute.sv
// Captures the pin select at byte start and steers the clock.
module sst_clkroute #(
  parameter int NPINS = 3,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SEL_W-1:0] sel,
  input  logic             sclk,
  output logic [NPINS-1:0] pins
);
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '1;
    else if (load) sel_q <= sel;
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign pins[i] = (sel_q == SEL_W'(i)) ? sclk : 1'b1;
  end

  // R9: at most one pin is ever driven low
  assert_one_pin_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~pins) <= 1);
endmodule

// File: rtl/sync_ser_tx.sv
// Clock-synchronous serial transmitter: buffer, flags and start gating.
module sync_ser_tx #(
  parameter int DATA_W   = 8,
  parameter int HALF_CYC = 4,
  parameter int NPINS    = 3,
  parameter int SEL_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              cts_n,
  input  logic              cts_ignore,
  input  logic [SEL_W-1:0]  clk_sel,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  output logic              s_ready,
  input  logic              irq_clr,
  output logic              sdata,
  output logic [NPINS-1:0]  sclk_pins,
  output logic              buf_empty,
  output logic              shreg_empty,
  output logic              irq_req
);
  logic [DATA_W-1:0] buf_q;
  logic wr, start_ok, load, load_win, tick, sclk_i, busy, tend;

  assign s_ready  = 1'b1;
  assign wr       = s_valid && s_ready;
  assign start_ok = tx_en && !buf_empty && (cts_ignore || !cts_n);
  assign load     = load_win && start_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q     <= '0;
      buf_empty <= 1'b1;
    end else if (wr) begin
      buf_q     <= s_data;
      buf_empty <= 1'b0;
    end else if (load) begin
      buf_empty <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg_empty <= 1'b1;
    else if (load) shreg_empty <= 1'b0;
    else if (tend) shreg_empty <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_req <= 1'b0;
    else if (load && !wr) irq_req <= 1'b1;
    else if (irq_clr) irq_req <= 1'b0;
  end

  sst_baud #(.HALF_CYC(HALF_CYC)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(busy), .restart(load), .tick(tick)
  );

  sst_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .din(buf_q), .tick(tick),
    .sclk(sclk_i), .sdata(sdata), .busy(busy), .tend(tend), .load_win(load_win)
  );

  sst_clkroute #(.NPINS(NPINS), .SEL_W(SEL_W)) u_route (
    .clk(clk), .rst_n(rst_n), .load(load), .sel(clk_sel), .sclk(sclk_i),
    .pins(sclk_pins)
  );

  // R1: the shift register is only ever claimed under the full start condition
  assert_start_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shreg_empty) |-> $past(tx_en && !buf_empty && (cts_ignore || !cts_n)));

  // R7: empty flag follows the end-of-byte marker by one cycle
  assert_empty_after_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tend) |=> shreg_empty);

  // R8: buffer hand-off raises the interrupt request
  assert_irq_on_handoff_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_empty) |-> irq_req);
endmodule

// File: tb/sim_sync_ser_tx.sv
module sim_sync_ser_tx;
  localparam int H = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0, cts_n = 1'b0, cts_ignore = 1'b0, s_valid = 1'b0, irq_clr = 1'b0;
  logic [1:0] clk_sel = 2'd0;
  logic [7:0] s_data = 8'h00;
  logic s_ready, sdata, buf_empty, shreg_empty, irq_req;
  logic [2:0] sclk_pins;

  always #2 clk = ~clk;

  sync_ser_tx #(.HALF_CYC(H)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .cts_n(cts_n), .cts_ignore(cts_ignore),
    .clk_sel(clk_sel), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .irq_clr(irq_clr), .sdata(sdata), .sclk_pins(sclk_pins), .buf_empty(buf_empty),
    .shreg_empty(shreg_empty), .irq_req(irq_req)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // monitor state
  logic       mon_clr = 1'b0;
  logic [2:0] prev_pins = 3'b111;
  int         rises [3];
  logic [7:0] rxsh;
  int         rxbits, rx_n;
  logic [7:0] rx [4];
  int         hi_run, lo_run, max_hi, max_lo;
  logic       se_at_last, se_next, last_pend;

  always @(negedge clk) begin
    if (mon_clr) begin
      for (int i = 0; i < 3; i++) rises[i] = 0;
      rxbits = 0; rx_n = 0; hi_run = 0; lo_run = 0; max_hi = 0; max_lo = 0;
      last_pend = 0;
    end else begin
      if (last_pend) begin se_next = shreg_empty; last_pend = 0; end
      for (int i = 0; i < 3; i++)
        if (!prev_pins[i] && sclk_pins[i]) rises[i]++;
      if (&prev_pins == 1'b0 && &sclk_pins == 1'b1) begin
        rxsh = {sdata, rxsh[7:1]};
        rxbits++;
        if (lo_run > max_lo) max_lo = lo_run;
        lo_run = 0;
        if (rxbits == 8) begin
          if (rx_n < 4) rx[rx_n] = rxsh;
          rx_n++; rxbits = 0;
          se_at_last = shreg_empty; last_pend = 1;
        end
      end
      if (&prev_pins == 1'b1 && &sclk_pins == 1'b0) begin
        if (hi_run > max_hi) max_hi = hi_run;
        hi_run = 0;
      end
      if (&sclk_pins) hi_run++; else lo_run++;
    end
    prev_pins = sclk_pins;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic mclear();
    @(negedge clk); mon_clr = 1'b1;
    @(negedge clk); mon_clr = 1'b0;
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk); s_valid = 1'b1; s_data = b;
    @(negedge clk); s_valid = 1'b0;
  endtask

  task automatic wait_rx(input int n, input string tag);
    int t = 0;
    while (rx_n < n && t < 600) begin @(negedge clk); t++; end
    check(rx_n >= n, tag, rx_n, n);
  endtask

  task automatic wait_start(input string tag);
    int t = 0;
    while (shreg_empty && t < 200) begin @(negedge clk); t++; end
    check(!shreg_empty, tag, shreg_empty, 0);
  endtask

  task automatic wait_idle(input string tag);
    int t = 0;
    while (!(shreg_empty && &sclk_pins) && t < 600) begin @(negedge clk); t++; end
    repeat (2 * H) @(negedge clk);
    check(shreg_empty == 1'b1, tag, shreg_empty, 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(buf_empty && shreg_empty && sdata && !irq_req && sclk_pins == 3'b111,
          "R11 reset state", {buf_empty, shreg_empty, sdata, irq_req, sclk_pins}, 7'b1110111);
    check(s_ready == 1'b1, "R4 ready high", s_ready, 1);
  endtask

  task automatic t_basic();
    tx_en = 1; cts_n = 0; clk_sel = 0;
    mclear();
    wr(8'hA5);
    wait_rx(1, "R3 byte arrives");
    check(rx[0] == 8'hA5, "R3 LSB-first data", rx[0], 8'hA5);
    check(rises[0] == 8 && rises[1] == 0 && rises[2] == 0, "R9 pin0 route",
          rises[0] * 100 + rises[1] * 10 + rises[2], 800);
    check(buf_empty == 1'b1, "R4 buffer empty after load", buf_empty, 1);
    check(irq_req == 1'b1, "R8 irq set on hand-off", irq_req, 1);
    @(negedge clk); @(negedge clk);
    check(se_at_last == 1'b0 && se_next == 1'b1, "R7 empty one cycle after last rise",
          {se_at_last, se_next}, 2'b01);
    wait_idle("R7 idle empty");
    check(sclk_pins == 3'b111 && sdata == 1'b1, "R9 idle pins high", {sclk_pins, sdata}, 4'hF);
    @(negedge clk); irq_clr = 1; @(negedge clk); irq_clr = 0;
    check(irq_req == 1'b0, "R8 irq cleared", irq_req, 0);
  endtask

  task automatic t_cts_block();
    cts_n = 1; mclear();
    wr(8'h3C);
    repeat (100) @(negedge clk);
    check(rises[0] == 0 && buf_empty == 1'b0 && shreg_empty == 1'b1, "R1 held by cts",
          rises[0], 0);
    cts_ignore = 1;
    wait_rx(1, "R2 bypass sends");
    check(rx[0] == 8'h3C, "R2 bypass data", rx[0], 8'h3C);
    wait_idle("R2 idle");
    cts_ignore = 0; cts_n = 0;
  endtask

  task automatic t_en_overwrite();
    tx_en = 0; mclear();
    wr(8'h11); wr(8'h22);
    repeat (80) @(negedge clk);
    check(rises[0] == 0 && buf_empty == 1'b0, "R1 held by enable", rises[0], 0);
    tx_en = 1;
    wait_rx(1, "R4 one byte");
    wait_idle("R4 idle");
    check(rx_n == 1 && rx[0] == 8'h22, "R4 overwrite keeps last", rx[0] + 256 * rx_n, 9'h122);
  endtask

  task automatic t_midbyte();
    mclear();
    wr(8'hC3);
    wait_start("R5 start");
    repeat (10) @(negedge clk);
    cts_n = 1; tx_en = 0; cts_ignore = 0;
    wait_rx(1, "R5 byte completes");
    check(rx[0] == 8'hC3 && rises[0] == 8, "R5 full byte despite controls", rx[0], 8'hC3);
    wait_idle("R5 idle");
    cts_n = 0; tx_en = 1;
  endtask

  task automatic t_b2b();
    int t = 0;
    mclear();
    wr(8'h5A);
    wait_start("R6 first start");
    hi_run = 0; max_hi = 0; max_lo = 0; lo_run = 0;
    while (!buf_empty && t < 50) begin @(negedge clk); t++; end
    wr(8'h96);
    wait_rx(2, "R6 two bytes");
    check(rx[0] == 8'h5A && rx[1] == 8'h96, "R6 data order", {rx[0], rx[1]}, 16'h5A96);
    check(max_hi == H, "R6 no gap between bytes", max_hi, H);
    check(max_lo == H, "R12 low half-period", max_lo, H);
    wait_idle("R6 idle");
  endtask

  task automatic t_route();
    clk_sel = 1; mclear(); wr(8'h0F); wait_rx(1, "R9 sel1 byte"); wait_idle("R9 idle1");
    check(rises[0] == 0 && rises[1] == 8 && rises[2] == 0, "R9 pin1 route",
          rises[0] * 100 + rises[1] * 10 + rises[2], 80);
    clk_sel = 2; mclear(); wr(8'hF0); wait_rx(1, "R9 sel2 byte"); wait_idle("R9 idle2");
    check(rises[0] == 0 && rises[1] == 0 && rises[2] == 8, "R9 pin2 route",
          rises[0] * 100 + rises[1] * 10 + rises[2], 8);
    clk_sel = 3; mclear(); wr(8'hFF); wait_start("R9 sel3 start");
    repeat (5) @(negedge clk);
    check(sclk_pins == 3'b111, "R9 sel3 pins high", sclk_pins, 3'b111);
    wait_idle("R9 idle3");
    check(rises[0] + rises[1] + rises[2] == 0, "R9 sel3 no pin", rises[0] + rises[1] + rises[2], 0);
  endtask

  task automatic t_sel_latch();
    clk_sel = 0; mclear();
    wr(8'h81);
    wait_start("R10 start");
    repeat (12) @(negedge clk);
    clk_sel = 2;
    wait_rx(1, "R10 byte");
    wait_idle("R10 idle");
    check(rises[0] == 8 && rises[2] == 0, "R10 select captured", rises[0] * 10 + rises[2], 80);
    clk_sel = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_cts_block();
    t_en_overwrite();
    t_midbyte();
    t_b2b();
    t_route();
    t_sel_latch();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual expired expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule